// File: doc/BRIEF.md
# Dual-Issue In-Order Dispatch Unit

This block sits between an instruction queue and a pair of execution units, one for integer work and one for floating-point work. Each cycle it inspects the two oldest queue entries, checks their register dependencies against each other and against a scoreboard of destinations still in flight, and sends zero, one or two of them onward. It always keeps program order. When it sends two, one goes to each unit.

The queue presents its two head slots with a valid bit each. The block answers with a pop count, which equals the number of instructions the units took in that cycle. Every accepted instruction marks its destination register as pending. A write-back clear port frees the register again. A synchronous flush drops everything pending and stops issue for that cycle.

Top module: `dual_issue_dispatch`

## Requirements
- R1: After reset no register is pending, and an empty queue (q_valid = 00) produces no issue and a pop count of 0.
- R2: The older slot (index 0) issues when it is valid and free of hazards. The unit is chosen by its kind bit (0 = integer, 1 = floating-point), and its destination field is forwarded to that unit.
- R3: Both slots issue in one cycle when they are of different kinds, neither is blocked, the younger has no dependence on the older, and both units are ready. Shared source registers do not prevent this.
- R4: When both slots are of the same kind, only the older one issues.
- R5: The younger slot is held when either of its sources equals the older slot's destination, or when both slots write the same destination.
- R6: An instruction whose sources or destination are pending in the scoreboard is held. While the older slot is held, the younger slot is never presented.
- R7: q_pop equals the number of handshakes completed on the two issue ports in that cycle. If the older instruction's unit is not ready, the younger one is not presented.
- R8: An accepted instruction's destination becomes pending from the next cycle. A clear on any write-back port frees the register from the next cycle, with no same-cycle bypass. A set and a clear of the same register in the same cycle leave it pending.
- R9: While flush is high nothing is issued and q_pop is 0. On the next cycle no register is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous flush of pending state |
| q_valid | input | 2 | Valid bit per head slot (bit 0 = older) |
| q_kind | input | 2 | Unit kind per slot, 0 integer, 1 floating-point |
| q_dst | input | 2*REG_W | Destination register per slot |
| q_srca | input | 2*REG_W | First source register per slot |
| q_srcb | input | 2*REG_W | Second source register per slot |
| q_pay | input | 2*PAY_W | Opaque payload per slot |
| q_pop | output | 2 | Number of entries taken this cycle |
| int_vld | output | 1 | Integer issue valid |
| int_rdy | input | 1 | Integer unit ready |
| int_dst | output | REG_W | Integer issue destination |
| int_srca | output | REG_W | Integer issue first source |
| int_srcb | output | REG_W | Integer issue second source |
| int_pay | output | PAY_W | Integer issue payload |
| fp_vld | output | 1 | Floating-point issue valid |
| fp_rdy | input | 1 | Floating-point unit ready |
| fp_dst | output | REG_W | Floating-point issue destination |
| fp_srca | output | REG_W | Floating-point issue first source |
| fp_srcb | output | REG_W | Floating-point issue second source |
| fp_pay | output | PAY_W | Floating-point issue payload |
| wb_clr_vld | input | NUM_CLR | Write-back clear strobes |
| wb_clr_idx | input | NUM_CLR*REG_W | Register freed by each clear strobe |

## Verification
The bench targets the pairing rule: same-kind pairs, each of the three ways the younger can depend on the older, and pairs that share only sources. A design that paired too eagerly would pop 2 where 1 is expected, and one that paired too cautiously would pop 1 on a legal mixed pair. It also checks a stalled older slot, whether blocked by the scoreboard or by an unready unit. A design that let the younger slip past would show a valid on the other port with nothing popped, or would pop out of order. Finally it checks the scoreboard's timing. A clear must not bypass in the same cycle, and a set must win over a simultaneous clear. A flush must not issue and must free every pending register, so a reversed priority shows up as a wrong pop count one cycle later.

// File: rtl/issue_pkg.sv
package issue_pkg;
   typedef enum logic {
      UNIT_INT = 1'b0,
      UNIT_FP  = 1'b1
   } unit_e;
endpackage

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
   parameter int REG_W   = 4,
   parameter int NUM_CLR = 2,
   localparam int NREG   = 1 << REG_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [1:0]               set_vld,
   input  logic [2*REG_W-1:0]       set_idx,
   input  logic [NUM_CLR-1:0]       clr_vld,
   input  logic [NUM_CLR*REG_W-1:0] clr_idx,
   output logic [NREG-1:0]          pend
);
   localparam logic [NREG-1:0] ONE = NREG'(1);

   logic [NREG-1:0] set_m;
   logic [NREG-1:0] clr_m;
   logic [NREG-1:0] clr_part [NUM_CLR];

   always_comb begin
      set_m = '0;
      for (int s = 0; s < 2; s++)
         if (set_vld[s]) set_m = set_m | (ONE << set_idx[s*REG_W +: REG_W]);
   end

   for (genvar c = 0; c < NUM_CLR; c++) begin : g_clr
      assign clr_part[c] = clr_vld[c] ? (ONE << clr_idx[c*REG_W +: REG_W]) : '0;
   end

   always_comb begin
      clr_m = '0;
      for (int c = 0; c < NUM_CLR; c++) clr_m = clr_m | clr_part[c];
   end

   // set takes priority over a clear of the same register
   always_ff @(posedge clk) begin
      if (!rst_n)     pend <= '0;
      else if (flush) pend <= '0;
      else            pend <= (pend & ~clr_m) | set_m;
   end

   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (pend == '0));

   assert_set_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vld[0] && !flush) |=> pend[$past(set_idx[REG_W-1:0])]);
endmodule

// File: rtl/issue_select.sv
module issue_select
   import issue_pkg::*;
#(
   parameter int REG_W      = 4,
   parameter bit ALLOW_DUAL = 1'b1,
   localparam int NREG      = 1 << REG_W
) (
   input  logic             flush,
   input  logic [1:0]       q_valid,
   input  logic [1:0]       q_kind,
   input  logic [REG_W-1:0] d0,
   input  logic [REG_W-1:0] a0,
   input  logic [REG_W-1:0] b0,
   input  logic [REG_W-1:0] d1,
   input  logic [REG_W-1:0] a1,
   input  logic [REG_W-1:0] b1,
   input  logic [NREG-1:0]  pend,
   input  logic             int_rdy,
   input  logic             fp_rdy,
   output logic [1:0]       iss,
   output logic [1:0]       acc
);
   logic hz0, hz1, link, rdy0, rdy1;

   assign hz0  = pend[a0] | pend[b0] | pend[d0];
   assign hz1  = pend[a1] | pend[b1] | pend[d1];
   assign link = (a1 == d0) | (b1 == d0) | (d1 == d0);
   assign rdy0 = (q_kind[0] == UNIT_INT) ? int_rdy : fp_rdy;
   assign rdy1 = (q_kind[1] == UNIT_INT) ? int_rdy : fp_rdy;

   assign iss[0] = !flush && q_valid[0] && !hz0;
   assign acc[0] = iss[0] && rdy0;

   if (ALLOW_DUAL) begin : g_dual
      assign iss[1] = acc[0] && q_valid[1] && (q_kind[1] != q_kind[0]) && !hz1 && !link;
   end else begin : g_single
      assign iss[1] = 1'b0;
   end

   assign acc[1] = iss[1] && rdy1;
endmodule

// File: rtl/issue_route.sv
module issue_route #(
   parameter int EW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic [EW-1:0] e0,
   input  logic [EW-1:0] e1,
   output logic          vld,
   output logic [EW-1:0] ent
);
   assign vld = |sel;
   assign ent = sel[1] ? e1 : e0;

   assert_one_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
   import issue_pkg::*;
#(
   parameter int REG_W      = 4,
   parameter int PAY_W      = 8,
   parameter int NUM_CLR    = 2,
   parameter bit ALLOW_DUAL = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [1:0]               q_valid,
   input  logic [1:0]               q_kind,
   input  logic [2*REG_W-1:0]       q_dst,
   input  logic [2*REG_W-1:0]       q_srca,
   input  logic [2*REG_W-1:0]       q_srcb,
   input  logic [2*PAY_W-1:0]       q_pay,
   output logic [1:0]               q_pop,
   output logic                     int_vld,
   input  logic                     int_rdy,
   output logic [REG_W-1:0]         int_dst,
   output logic [REG_W-1:0]         int_srca,
   output logic [REG_W-1:0]         int_srcb,
   output logic [PAY_W-1:0]         int_pay,
   output logic                     fp_vld,
   input  logic                     fp_rdy,
   output logic [REG_W-1:0]         fp_dst,
   output logic [REG_W-1:0]         fp_srca,
   output logic [REG_W-1:0]         fp_srcb,
   output logic [PAY_W-1:0]         fp_pay,
   input  logic [NUM_CLR-1:0]       wb_clr_vld,
   input  logic [NUM_CLR*REG_W-1:0] wb_clr_idx
);
   localparam int NREG = 1 << REG_W;
   localparam int EW   = PAY_W + 3*REG_W;

   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
      $error("REG_W must lie in 1..8");
   end
   if (PAY_W < 1) begin : g_bad_pay_w
      $error("PAY_W must be at least 1");
   end
   if (NUM_CLR < 1) begin : g_bad_clr
      $error("NUM_CLR must be at least 1");
   end

   logic [NREG-1:0] pend;
   logic [1:0]      iss, acc;
   logic [1:0]      sel_int, sel_fp;
   logic [EW-1:0]   e0, e1, ent_int, ent_fp;

   issue_scoreboard #(.REG_W(REG_W), .NUM_CLR(NUM_CLR)) u_sb (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .set_vld(acc), .set_idx(q_dst),
      .clr_vld(wb_clr_vld), .clr_idx(wb_clr_idx),
      .pend(pend)
   );

   issue_select #(.REG_W(REG_W), .ALLOW_DUAL(ALLOW_DUAL)) u_sel (
      .flush(flush), .q_valid(q_valid), .q_kind(q_kind),
      .d0(q_dst[0 +: REG_W]),  .a0(q_srca[0 +: REG_W]),  .b0(q_srcb[0 +: REG_W]),
      .d1(q_dst[REG_W +: REG_W]), .a1(q_srca[REG_W +: REG_W]), .b1(q_srcb[REG_W +: REG_W]),
      .pend(pend), .int_rdy(int_rdy), .fp_rdy(fp_rdy),
      .iss(iss), .acc(acc)
   );

   assign e0 = {q_pay[0 +: PAY_W], q_dst[0 +: REG_W], q_srca[0 +: REG_W], q_srcb[0 +: REG_W]};
   assign e1 = {q_pay[PAY_W +: PAY_W], q_dst[REG_W +: REG_W],
                q_srca[REG_W +: REG_W], q_srcb[REG_W +: REG_W]};

   for (genvar s = 0; s < 2; s++) begin : g_steer
      assign sel_int[s] = iss[s] && (q_kind[s] == UNIT_INT);
      assign sel_fp[s]  = iss[s] && (q_kind[s] == UNIT_FP);
   end

   issue_route #(.EW(EW)) u_rt_int (
      .clk(clk), .rst_n(rst_n), .sel(sel_int), .e0(e0), .e1(e1),
      .vld(int_vld), .ent(ent_int)
   );

   issue_route #(.EW(EW)) u_rt_fp (
      .clk(clk), .rst_n(rst_n), .sel(sel_fp), .e0(e0), .e1(e1),
      .vld(fp_vld), .ent(ent_fp)
   );

   assign int_pay  = ent_int[EW-1 -: PAY_W];
   assign int_dst  = ent_int[3*REG_W-1 -: REG_W];
   assign int_srca = ent_int[2*REG_W-1 -: REG_W];
   assign int_srcb = ent_int[REG_W-1:0];
   assign fp_pay   = ent_fp[EW-1 -: PAY_W];
   assign fp_dst   = ent_fp[3*REG_W-1 -: REG_W];
   assign fp_srca  = ent_fp[2*REG_W-1 -: REG_W];
   assign fp_srcb  = ent_fp[REG_W-1:0];

   assign q_pop = {1'b0, acc[0]} + {1'b0, acc[1]};

   assert_pair_mixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (int_vld && fp_vld) |-> (q_valid == 2'b11 && q_kind[0] != q_kind[1]));

   assert_pop_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop != 2'd0) |-> (q_valid[0] && q_pop != 2'd3 && (q_pop != 2'd2 || q_valid[1])));

   assert_pop_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop == 2'd2) |-> (int_vld && int_rdy && fp_vld && fp_rdy));

   assert_flush_no_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (q_pop == 2'd0 && !int_vld && !fp_vld));

   assert_int_src_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (int_vld && int_rdy) |-> (!pend[int_srca] && !pend[int_srcb] && !pend[int_dst]));

   assert_fp_src_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_vld && fp_rdy) |-> (!pend[fp_srca] && !pend[fp_srcb] && !pend[fp_dst]));
endmodule

// File: tb/sim_dual_issue_dispatch.sv
module sim_dual_issue_dispatch;
   localparam int RW = 4;
   localparam int PW = 8;

   typedef struct packed {
      logic [1:0] v;
      logic [1:0] k;
      logic [3:0] d0, a0, b0, d1, a1, b1;
      logic       ir, fr, ei, ef;
      logic [1:0] ep;
      logic [3:0] xi, xf;
      logic [3:0] rq;
   } vec_t;

   // kind bit per slot: 0 integer, 1 floating-point; bit 0 is the older slot
   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{2'b01, 2'b00, 1, 2, 3, 0, 0, 0, 1, 1, 1, 0, 1, 1, 0, 2},  // R2 lone int
      '{2'b01, 2'b01, 1, 2, 3, 0, 0, 0, 1, 1, 0, 1, 1, 0, 1, 2},  // R2 lone fp
      '{2'b11, 2'b10, 1, 2, 3, 4, 5, 6, 1, 1, 1, 1, 2, 1, 4, 3},  // R3 int then fp
      '{2'b11, 2'b01, 1, 2, 3, 4, 5, 6, 1, 1, 1, 1, 2, 4, 1, 3},  // R3 fp then int
      '{2'b11, 2'b10, 1, 2, 3, 4, 2, 3, 1, 1, 1, 1, 2, 1, 4, 3},  // R3 shared sources
      '{2'b11, 2'b00, 1, 2, 3, 4, 5, 6, 1, 1, 1, 0, 1, 1, 0, 4},  // R4 two int
      '{2'b11, 2'b11, 1, 2, 3, 4, 5, 6, 1, 1, 0, 1, 1, 0, 1, 4},  // R4 two fp
      '{2'b11, 2'b10, 1, 2, 3, 4, 1, 6, 1, 1, 1, 0, 1, 1, 0, 5},  // R5 srca on older dst
      '{2'b11, 2'b10, 1, 2, 3, 4, 5, 1, 1, 1, 1, 0, 1, 1, 0, 5},  // R5 srcb on older dst
      '{2'b11, 2'b10, 1, 2, 3, 1, 5, 6, 1, 1, 1, 0, 1, 1, 0, 5},  // R5 same dst
      '{2'b11, 2'b10, 1, 2, 3, 4, 5, 6, 0, 1, 1, 0, 0, 1, 0, 7},  // R7 int unit busy
      '{2'b11, 2'b10, 1, 2, 3, 4, 5, 6, 1, 0, 1, 1, 1, 1, 4, 7},  // R7 fp unit busy
      '{2'b00, 2'b10, 1, 2, 3, 4, 5, 6, 1, 1, 0, 0, 0, 0, 0, 1}   // R1 empty queue
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic [1:0] q_valid = '0, q_kind = '0;
   logic [2*RW-1:0] q_dst = '0, q_srca = '0, q_srcb = '0;
   logic [2*PW-1:0] q_pay = 16'hB1A0;
   logic [1:0] q_pop;
   logic int_vld, fp_vld;
   logic int_rdy = 1'b1, fp_rdy = 1'b1;
   logic [RW-1:0] int_dst, int_srca, int_srcb, fp_dst, fp_srca, fp_srcb;
   logic [PW-1:0] int_pay, fp_pay;
   logic [1:0] wb_clr_vld = '0;
   logic [2*RW-1:0] wb_clr_idx = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dual_issue_dispatch #(.REG_W(RW), .PAY_W(PW), .NUM_CLR(2)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .q_valid(q_valid), .q_kind(q_kind), .q_dst(q_dst), .q_srca(q_srca),
      .q_srcb(q_srcb), .q_pay(q_pay), .q_pop(q_pop),
      .int_vld(int_vld), .int_rdy(int_rdy), .int_dst(int_dst),
      .int_srca(int_srca), .int_srcb(int_srcb), .int_pay(int_pay),
      .fp_vld(fp_vld), .fp_rdy(fp_rdy), .fp_dst(fp_dst),
      .fp_srca(fp_srca), .fp_srcb(fp_srcb), .fp_pay(fp_pay),
      .wb_clr_vld(wb_clr_vld), .wb_clr_idx(wb_clr_idx)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_q(input logic [1:0] v, input logic [1:0] k,
                        input logic [3:0] d0, a0, b0, d1, a1, b1);
      q_valid = v; q_kind = k;
      q_dst = {d1, d0}; q_srca = {a1, a0}; q_srcb = {b1, b0};
   endtask

   task automatic do_flush();
      @(negedge clk);
      q_valid = '0; flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 pop after reset", q_pop, 0);
      chk("R1 int_vld after reset", int_vld, 0);
      chk("R1 fp_vld after reset", fp_vld, 0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         set_q(VEC[i].v, VEC[i].k, VEC[i].d0, VEC[i].a0, VEC[i].b0,
               VEC[i].d1, VEC[i].a1, VEC[i].b1);
         int_rdy = VEC[i].ir; fp_rdy = VEC[i].fr;
         #1;
         chk($sformatf("R%0d vec%0d pop", VEC[i].rq, i), q_pop, VEC[i].ep);
         chk($sformatf("R%0d vec%0d int_vld", VEC[i].rq, i), int_vld, VEC[i].ei);
         chk($sformatf("R%0d vec%0d fp_vld", VEC[i].rq, i), fp_vld, VEC[i].ef);
         if (VEC[i].ei) chk($sformatf("R%0d vec%0d int_dst", VEC[i].rq, i), int_dst, VEC[i].xi);
         if (VEC[i].ef) chk($sformatf("R%0d vec%0d fp_dst", VEC[i].rq, i), fp_dst, VEC[i].xf);
         int_rdy = 1'b1; fp_rdy = 1'b1;
         do_flush();
      end

      // R8 / R6: pending destination blocks a later reader, clear has no bypass
      @(negedge clk);
      set_q(2'b01, 2'b00, 5, 1, 2, 0, 0, 0);
      #1 chk("R8 issue writer of r5", q_pop, 1);
      @(negedge clk);
      set_q(2'b11, 2'b10, 6, 5, 1, 7, 8, 9);
      wb_clr_vld = 2'b01; wb_clr_idx = {4'd0, 4'd5};
      #1;
      chk("R6 older reads pending r5 pop", q_pop, 0);
      chk("R6 younger not presented fp_vld", fp_vld, 0);
      chk("R8 clear has no bypass int_vld", int_vld, 0);
      @(negedge clk);
      wb_clr_vld = 2'b00;
      #1 chk("R8 freed r5 lets pair go", q_pop, 2);
      @(negedge clk);
      set_q(2'b01, 2'b01, 9, 7, 1, 0, 0, 0);
      #1 chk("R8 younger dst r7 marked pending", q_pop, 0);
      do_flush();

      // R8: set wins over same-cycle clear
      @(negedge clk);
      set_q(2'b01, 2'b00, 3, 1, 2, 0, 0, 0);
      wb_clr_vld = 2'b10; wb_clr_idx = {4'd3, 4'd0};
      #1 chk("R8 issue with clear of same reg", q_pop, 1);
      @(negedge clk);
      wb_clr_vld = 2'b00;
      set_q(2'b01, 2'b01, 4, 3, 1, 0, 0, 0);
      #1 chk("R8 set wins over clear", q_pop, 0);

      // R6: younger reads a pending register, older free
      @(negedge clk);
      set_q(2'b11, 2'b10, 10, 1, 2, 11, 3, 1);
      #1;
      chk("R6 younger pending source pop", q_pop, 1);
      chk("R6 younger pending source fp_vld", fp_vld, 0);
      @(negedge clk);
      set_q(2'b01, 2'b00, 3, 1, 2, 0, 0, 0);
      #1 chk("R6 pending destination blocks", q_pop, 0);

      // R9: flush stops issue and frees r3 and r10
      @(negedge clk);
      set_q(2'b01, 2'b01, 12, 1, 2, 0, 0, 0);
      flush = 1'b1;
      #1;
      chk("R9 no pop during flush", q_pop, 0);
      chk("R9 no fp_vld during flush", fp_vld, 0);
      @(negedge clk);
      flush = 1'b0;
      set_q(2'b01, 2'b01, 12, 3, 10, 0, 0, 0);
      #1 chk("R9 pending cleared by flush", q_pop, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule